// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block collects the interrupt conditions of a 16550-style UART and presents the most urgent one as a single 8-bit status value with an active-high request line. It ranks seven conditions on six priority levels: line status error, receive timeout and receive data ready (which share a level), transmit ready, modem status change, Xoff or special character detected, and CTS/RTS change. The two lowest levels are extended sources. They reach the status value only while the enhanced-feature enable input is high.

Line status errors, modem status changes, Xoff detection and CTS/RTS changes arrive as one-cycle pulses. Each pulse is held in a pending flag until its own service strobe clears it. The Xoff flag is the exception: it clears only when an Xon character is detected. The two receive conditions are levels that the receive path supplies. Transmit ready is derived inside the block: it compares the transmit FIFO fill count against a threshold chosen by a 2-bit select. The status value is registered. The choice of what to show is made again on every clock, so a more urgent source replaces the shown code without a read.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is low, and on the first cycle after it, the status reads 0x01 and the request line is low. All pending flags are cleared.
- R2: Bits 5:0 carry the code of the highest pending source only. Priority runs from line status (000110), then receive timeout (001100), then receive data ready (000100), then transmit ready (000010), then modem status (000000), then Xoff/special character (010000), then CTS/RTS change (100000).
- R3: With nothing pending, bits 5:0 read 000001 and the request line is low. With any source pending, bit 0 is 0 and the request line is high.
- R4: The status is updated every clock without a read. A level source shows one cycle after its input rises. A pulsed source shows two cycles after its pulse. A more urgent source replaces a less urgent code.
- R5: While the enhanced-feature enable is 0, bits 5:4 read 0 and the Xoff and CTS/RTS sources are not reported. Their flags still record events, and those events appear once the enable is set.
- R6: Bits 7:6 read 11 while the FIFO-enable input is 1 and 00 while it is 0.
- R7: Once set, the Xoff flag stays set through status reads and enable changes. Only an Xon detection pulse clears it.
- R8: In FIFO mode the transmitter is ready when (depth − fill) is at least the threshold chosen by the select. For a 32-deep FIFO the select maps 00→16, 01→8, 10→24 and 11→30. In non-FIFO mode the transmitter is ready when fill is 0. The transmit source becomes pending when ready rises and clears when ready falls. Out of reset the transmitter counts as already ready.
- R9: A status read while the transmit code is shown clears the transmit source. A status read while any other code is shown changes no pending state.
- R10: Line status, modem status and CTS/RTS flags clear on their own service strobes. A new event in the same cycle as its strobe keeps the flag set.
- R11: The receive timeout and receive data ready sources follow their input levels. There is no latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enable |
| ext_en | input | 1 | Enhanced-feature enable; gates the extended sources |
| lsr_err | input | 1 | Line status error event pulse |
| rx_ready | input | 1 | Receive data ready level |
| rx_timeout | input | 1 | Receive timeout level |
| tx_fill | input | 6 | Transmit FIFO fill count |
| tx_trig | input | 2 | Transmit threshold select |
| msr_chg | input | 1 | Modem status change event pulse |
| xoff_det | input | 1 | Xoff or special character detected pulse |
| xon_det | input | 1 | Xon character detected pulse |
| flow_chg | input | 1 | CTS/RTS change event pulse |
| isr_rd | input | 1 | Status register read strobe |
| lsr_rd | input | 1 | Line status service strobe |
| msr_rd | input | 1 | Modem status service strobe |
| flow_ack | input | 1 | CTS/RTS change acknowledge strobe |
| isr_q | output | 8 | Interrupt status value |
| irq | output | 1 | Interrupt request |

## Verification
The ranking is driven with sources raised one at a time, then stacked, so that preemption and fallback to the next level each show in the code sequence. All four threshold selects are stepped across their exact boundary fill values in FIFO mode, and the empty rule is checked in non-FIFO mode. These cases separate a correct threshold from an off-by-one. Status reads are issued while transmit and non-transmit codes are shown, which tells a read that clears from one that must not. The extended sources are raised with the enable low and then high, with Xon and status reads interleaved. Line status events are made to coincide with their own strobe, which shows that a set wins over a clear.

// File: rtl/uart_irq_pkg.sv
// Package: shared constants and helpers for the UART interrupt identifier.
// Assumes: source indices below define the priority order (index 0 highest).
package uart_irq_pkg;

    localparam int NSRC   = 7;
    localparam int L_LSR  = 0;
    localparam int L_RXTO = 1;
    localparam int L_RXRD = 2;
    localparam int L_TX   = 3;
    localparam int L_MSR  = 4;
    localparam int L_XOFF = 5;
    localparam int L_FLOW = 6;

    localparam int NSTICKY = 4;
    localparam int S_LSR   = 0;
    localparam int S_MSR   = 1;
    localparam int S_XOFF  = 2;
    localparam int S_FLOW  = 3;

    localparam logic [5:0] IDLE_CODE = 6'b000001;
    localparam logic [5:0] TX_CODE   = 6'b000010;

    // Map a source index to its 6-bit identification code.
    function automatic logic [5:0] level_code(input int idx);
        case (idx)
            L_LSR:   level_code = 6'b000110;
            L_RXTO:  level_code = 6'b001100;
            L_RXRD:  level_code = 6'b000100;
            L_TX:    level_code = 6'b000010;
            L_MSR:   level_code = 6'b000000;
            L_XOFF:  level_code = 6'b010000;
            L_FLOW:  level_code = 6'b100000;
            default: level_code = IDLE_CODE;
        endcase
    endfunction

    // Threshold in free slots for a select value, scaled to the FIFO depth.
    function automatic int unsigned tx_threshold(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'b00:   tx_threshold = depth / 2;
            2'b01:   tx_threshold = depth / 4;
            2'b10:   tx_threshold = (depth * 3) / 4;
            default: tx_threshold = depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_flag.sv
// Module: sticky pending flag for one pulsed interrupt source.
// Assumes: set and clear are single-cycle strobes; set wins when both occur.
module uart_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // Hold the pending state; a set in the same cycle as a clear keeps it set.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(set_i) |-> q_o);

    a_r10_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(clr_i && !set_i) |-> !q_o);

endmodule

// File: rtl/uart_irq_txsrc.sv
// Module: transmit-ready interrupt source.
// Compares the fill count with the selected threshold (FIFO mode) or with empty
// (non-FIFO mode), arms on a rising ready, clears on a falling ready or on a
// status read that sees the transmit code.
// Assumes: tx_fill never exceeds DEPTH.
module uart_irq_txsrc
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [CW-1:0] fill_i,
    input  logic [1:0]    sel_i,
    input  logic          rd_clr_i,
    output logic          pend_o
);

    logic [CW:0] thr;
    logic        ready;
    logic        ready_prev;
    logic        rise;

    // Ready when free slots meet the threshold, or when empty without FIFOs.
    always_comb begin
        thr = (CW + 1)'(tx_threshold(sel_i, DEPTH));
        if (fifo_en) ready = ({1'b0, fill_i} + thr) <= (CW + 1)'(DEPTH);
        else         ready = (fill_i == '0);
        rise = ready && !ready_prev;
    end

    // Remember last ready; out of reset the transmitter counts as reported.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_prev <= 1'b1;
        else        ready_prev <= ready;
    end

    // Pending state: rising ready sets, falling ready or a clearing read clears.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_o <= 1'b0;
        else if (rise)     pend_o <= 1'b1;
        else if (!ready)   pend_o <= 1'b0;
        else if (rd_clr_i) pend_o <= 1'b0;
    end

    a_r8_rise_arms: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ready && !ready_prev) |-> pend_o);

    a_r8_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!ready) |-> !pend_o);

    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rd_clr_i && ready_prev) |-> !pend_o);

endmodule

// File: rtl/uart_irq_prio.sv
// Module: fixed-priority selector over the pending request vector.
// Index 0 is most urgent; outputs the winner's code and whether any is pending.
// Assumes: req_i already has the extended sources gated.
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0] req_i,
    output logic [5:0]      code_o,
    output logic            any_o
);

    logic [NSRC-1:0] grant;
    logic [NSRC:0]   above;

    assign above[0] = 1'b0;

    for (genvar i = 0; i < NSRC; i++) begin : g_chain
        assign grant[i]     = req_i[i] && !above[i];
        assign above[i + 1] = above[i] || req_i[i];
    end

    assign any_o = above[NSRC];

    // Merge the code of the single granted source.
    always_comb begin
        code_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) code_o = code_o | level_code(i);
        end
    end

    // At most one grant, and a grant whenever something is requested.
    always_comb begin
        a_r2_single_grant: assert ($onehot0(grant));
        a_r2_grant_if_req: assert ((req_i == '0) || (grant != '0));
    end

endmodule

// File: rtl/uart_irq_ident.sv
// Module: UART interrupt identifier top.
// Latches pulsed sources, derives the transmit source, ranks all seven sources
// and registers the 8-bit status with FIFO-mode bits on top.
// Assumes: event and strobe inputs are single-cycle, synchronous to clk.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int TX_DEPTH = 32,
    localparam int CW      = $clog2(TX_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          ext_en,
    input  logic          lsr_err,
    input  logic          rx_ready,
    input  logic          rx_timeout,
    input  logic [CW-1:0] tx_fill,
    input  logic [1:0]    tx_trig,
    input  logic          msr_chg,
    input  logic          xoff_det,
    input  logic          xon_det,
    input  logic          flow_chg,
    input  logic          isr_rd,
    input  logic          lsr_rd,
    input  logic          msr_rd,
    input  logic          flow_ack,
    output logic [7:0]    isr_q,
    output logic          irq
);

    logic [NSTICKY-1:0] st_set;
    logic [NSTICKY-1:0] st_clr;
    logic [NSTICKY-1:0] st_q;
    logic               tx_pend;
    logic [NSRC-1:0]    req;
    logic [5:0]         win_code;
    logic               win_any;
    logic [7:0]         stat_q;
    logic               irq_q;

    assign st_set = {flow_chg, xoff_det, msr_chg, lsr_err};
    assign st_clr = {flow_ack, xon_det,  msr_rd,  lsr_rd};

    for (genvar k = 0; k < NSTICKY; k++) begin : g_sticky
        uart_irq_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (st_set[k]),
            .clr_i (st_clr[k]),
            .q_o   (st_q[k])
        );
    end

    uart_irq_txsrc #(.DEPTH(TX_DEPTH)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .fill_i   (tx_fill),
        .sel_i    (tx_trig),
        .rd_clr_i (isr_rd && (stat_q[5:0] == TX_CODE)),
        .pend_o   (tx_pend)
    );

    // Build the request vector in priority order, gating the extended sources.
    always_comb begin
        req         = '0;
        req[L_LSR]  = st_q[S_LSR];
        req[L_RXTO] = rx_timeout;
        req[L_RXRD] = rx_ready;
        req[L_TX]   = tx_pend;
        req[L_MSR]  = st_q[S_MSR];
        req[L_XOFF] = ext_en && st_q[S_XOFF];
        req[L_FLOW] = ext_en && st_q[S_FLOW];
    end

    uart_irq_prio u_prio (
        .req_i  (req),
        .code_o (win_code),
        .any_o  (win_any)
    );

    // Register the status value and request line every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= {2'b00, IDLE_CODE};
            irq_q  <= 1'b0;
        end else begin
            stat_q <= {{2{fifo_en}}, (win_any ? win_code : IDLE_CODE)};
            irq_q  <= win_any;
        end
    end

    assign isr_q = stat_q;
    assign irq   = irq_q;

    a_r3_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[0] |-> (stat_q[5:1] == 5'b0) && !irq_q);

    a_r3_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> !stat_q[0]);

    a_r2_lsr_top: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(st_q[S_LSR]) |-> stat_q[5:0] == 6'b000110);

    a_r5_ext_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(ext_en) |-> stat_q[5:4] == 2'b00);

    a_r6_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stat_q[7:6] == {2{$past(fifo_en)}});

    a_r7_xoff_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(st_q[S_XOFF]) && !$past(xon_det) |-> st_q[S_XOFF]);

endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0, ext_en = 1'b0;
    logic       lsr_err = 1'b0, rx_ready = 1'b0, rx_timeout = 1'b0;
    logic [5:0] tx_fill = 6'd0;
    logic [1:0] tx_trig = 2'b00;
    logic       msr_chg = 1'b0, xoff_det = 1'b0, xon_det = 1'b0, flow_chg = 1'b0;
    logic       isr_rd = 1'b0, lsr_rd = 1'b0, msr_rd = 1'b0, flow_ack = 1'b0;
    logic [7:0] isr_q;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_irq_ident u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ext_en(ext_en),
        .lsr_err(lsr_err), .rx_ready(rx_ready), .rx_timeout(rx_timeout),
        .tx_fill(tx_fill), .tx_trig(tx_trig), .msr_chg(msr_chg),
        .xoff_det(xoff_det), .xon_det(xon_det), .flow_chg(flow_chg),
        .isr_rd(isr_rd), .lsr_rd(lsr_rd), .msr_rd(msr_rd), .flow_ack(flow_ack),
        .isr_q(isr_q), .irq(irq)
    );

    // Behavioural reference model, advanced on every rising edge.
    logic [7:0] m_stat = 8'h01;
    logic       m_irq = 1'b0;
    bit m_lsr, m_msr, m_xoff, m_flow, m_tx, m_prev;

    function automatic int thr_for(input logic [1:0] s);
        case (s)
            2'b00: return 16;
            2'b01: return 8;
            2'b10: return 24;
            default: return 30;
        endcase
    endfunction

    always @(posedge clk) begin
        bit rdy, pend;
        logic [5:0] code;
        if (!rst_n) begin
            m_stat = 8'h01; m_irq = 1'b0;
            m_lsr = 0; m_msr = 0; m_xoff = 0; m_flow = 0; m_tx = 0; m_prev = 1;
        end else begin
            pend = 1; code = 6'b000001;
            if (m_lsr)                 code = 6'b000110;
            else if (rx_timeout)       code = 6'b001100;
            else if (rx_ready)         code = 6'b000100;
            else if (m_tx)             code = 6'b000010;
            else if (m_msr)            code = 6'b000000;
            else if (ext_en && m_xoff) code = 6'b010000;
            else if (ext_en && m_flow) code = 6'b100000;
            else                       pend = 0;
            rdy = fifo_en ? ((32 - int'(tx_fill)) >= thr_for(tx_trig)) : (tx_fill == 0);
            if (rdy && !m_prev)                             m_tx = 1;
            else if (!rdy)                                  m_tx = 0;
            else if (isr_rd && m_stat[5:0] == 6'b000010)    m_tx = 0;
            m_prev = rdy;
            m_lsr  = lsr_err  ? 1 : (lsr_rd   ? 0 : m_lsr);
            m_msr  = msr_chg  ? 1 : (msr_rd   ? 0 : m_msr);
            m_xoff = xoff_det ? 1 : (xon_det  ? 0 : m_xoff);
            m_flow = flow_chg ? 1 : (flow_ack ? 0 : m_flow);
            m_stat = {fifo_en ? 2'b11 : 2'b00, code};
            m_irq  = pend;
        end
    end

    // Per-cycle comparison against the model (R2, R4 ordering and timing).
    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (isr_q !== m_stat || irq !== m_irq) begin
                n_bad++;
                $display("FAIL R4 per-cycle t=%0t: isr=%02h irq=%0b expected isr=%02h irq=%0b",
                         $time, isr_q, irq, m_stat, m_irq);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] exp_isr);
        logic exp_irq;
        exp_irq = !exp_isr[0];
        n_chk++;
        if (isr_q !== exp_isr || irq !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: isr=%02h irq=%0b expected isr=%02h irq=%0b",
                     tag, isr_q, irq, exp_isr, exp_irq);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200_000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        chk("R1 in reset", 8'h01);
        rst_n = 1'b1;
        tick(1);
        chk("R1 after reset", 8'h01);

        fifo_en = 1'b1; tick(2);
        chk("R6 fifo bits set, R3 idle", 8'hC1);

        msr_chg = 1; tick(1); msr_chg = 0; tick(1);
        chk("R3 modem pending", 8'hC0);
        lsr_err = 1; tick(1); lsr_err = 0; tick(1);
        chk("R4 line status preempts", 8'hC6);
        isr_rd = 1; tick(1); isr_rd = 0; tick(2);
        chk("R9 read keeps line status", 8'hC6);
        lsr_rd = 1; tick(1); lsr_rd = 0; tick(1);
        chk("R10 lsr strobe clears, R2 modem next", 8'hC0);
        msr_rd = 1; tick(1); msr_rd = 0; tick(1);
        chk("R10 msr strobe clears", 8'hC1);

        rx_ready = 1; tick(1);
        chk("R11 rx ready level", 8'hC4);
        rx_timeout = 1; tick(1);
        chk("R2 timeout over ready", 8'hCC);
        rx_timeout = 0; tick(1);
        chk("R11 timeout drop", 8'hC4);
        rx_ready = 0; tick(1);
        chk("R11 ready drop", 8'hC1);

        tx_fill = 6'd20; tick(2);
        chk("R8 sel00 fill20 not ready", 8'hC1);
        tx_fill = 6'd16; tick(3);
        chk("R8 sel00 fill16 ready", 8'hC2);
        tx_trig = 2'b01; tx_fill = 6'd25; tick(3);
        chk("R8 sel01 fill25 drop clears", 8'hC1);
        tx_fill = 6'd24; tick(3);
        chk("R8 sel01 fill24 ready", 8'hC2);
        isr_rd = 1; tick(1); isr_rd = 0; tick(2);
        chk("R9 read clears transmit", 8'hC1);
        tx_trig = 2'b10; tx_fill = 6'd9; tick(3);
        chk("R8 sel10 fill9 not ready", 8'hC1);
        tx_fill = 6'd8; tick(3);
        chk("R8 sel10 fill8 ready", 8'hC2);
        isr_rd = 1; tick(1); isr_rd = 0; tick(2);
        tx_trig = 2'b11; tx_fill = 6'd3; tick(3);
        chk("R8 sel11 fill3 not ready", 8'hC1);
        tx_fill = 6'd2; tick(3);
        chk("R8 sel11 fill2 ready", 8'hC2);
        isr_rd = 1; tick(1); isr_rd = 0; tick(2);
        chk("R9 read clears transmit again", 8'hC1);

        xoff_det = 1; tick(1); xoff_det = 0; tick(2);
        chk("R5 xoff hidden when disabled", 8'hC1);
        flow_chg = 1; tick(1); flow_chg = 0; tick(2);
        chk("R5 flow hidden when disabled", 8'hC1);
        ext_en = 1; tick(2);
        chk("R5 enable reveals xoff, R2 over flow", 8'hD0);
        isr_rd = 1; tick(1); isr_rd = 0; tick(2);
        chk("R7 xoff survives read", 8'hD0);
        ext_en = 0; tick(2); ext_en = 1; tick(2);
        chk("R7 xoff survives enable toggle", 8'hD0);
        xon_det = 1; tick(1); xon_det = 0; tick(2);
        chk("R7 xon clears, flow next", 8'hE0);
        flow_ack = 1; tick(1); flow_ack = 0; tick(2);
        chk("R10 flow ack clears", 8'hC1);

        lsr_err = 1; lsr_rd = 1; tick(1); lsr_err = 0; lsr_rd = 0; tick(2);
        chk("R10 set wins over strobe", 8'hC6);
        lsr_rd = 1; tick(1); lsr_rd = 0; tick(2);
        chk("R10 later strobe clears", 8'hC1);

        fifo_en = 0; tick(3);
        chk("R6 fifo bits clear, R8 non-fifo fill2 not ready", 8'h01);
        tx_fill = 6'd0; tick(3);
        chk("R8 non-fifo empty ready", 8'h02);
        isr_rd = 1; tick(1); isr_rd = 0; tick(2);
        chk("R9 non-fifo read clears", 8'h01);

        rst_n = 0; msr_chg = 1; tick(1); msr_chg = 0; tick(1);
        chk("R1 reset mid-run", 8'h01);
        rst_n = 1; tick(2);
        chk("R1 flags cleared by reset", 8'h01);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule